// File: doc/BRIEF.md
# Holdover Frequency Word Controller

This block sits between a digital loop filter and a numerically controlled oscillator. While the reference is good, it forwards the loop's frequency control word to the oscillator. In the background it keeps a shift-based exponential average of that word.

When the reference disappears, the output stops following the loop at once and is parked on the average. After that, only small corrections from an external steering input reach the output. Each correction is clamped in size and spaced out in time. A wall-clock limit on holdover raises an alarm when it runs out.

When the reference comes back, it must stay good for a programmable number of updates before anything moves. The output then walks toward the live loop word in bounded steps (capture). It hands control back to the loop once the two are close. Everything advances only on an update strobe, so every limit counts strobes, not clocks.

Top module: `hfc_holdover_ctrl`

## Requirements
- R1: After reset the output word is 0, the alarm is low and the state code is TRACK. State codes are TRACK=0, FREEZE=1, STEER=2, CAPTURE=3, on a 3-bit output.
- R2: In TRACK, on a strobe with the reference valid, the output word takes the loop word. The average is updated as avg + ((loop − avg) >>> shift), using signed arithmetic one bit wider than the word, with the shift taken from its configuration input. The average is also updated on valid-reference strobes in CAPTURE.
- R3: In TRACK, a strobe with the reference invalid moves the block to FREEZE. The output word becomes the average as it stood before that strobe, and the loop word is ignored.
- R4: FREEZE lasts exactly one strobe with the output word unchanged. It then moves to STEER, or to CAPTURE if the eligibility window completes on that strobe.
- R5: In STEER, the steering delta is clamped to ±step limit before it is added to the output word. A delta is applied on the first STEER strobe, and after that only once every gap+1 strobes.
- R6: In FREEZE or STEER, the reference must be valid on `elig` consecutive strobes (a value of 0 counts as 1) before the block enters CAPTURE. An invalid strobe restarts the count. Entry into CAPTURE leaves the output word unchanged and applies no steering.
- R7: In CAPTURE, on a valid strobe, the output word moves toward the loop word by the difference clamped to ±recovery step. If the difference before the move is within ±tolerance, the state becomes TRACK.
- R8: In CAPTURE, a strobe with the reference invalid returns the block to FREEZE and leaves the output word exactly as it was.
- R9: Holdover strobes are counted from entry into FREEZE, saturating at the counter maximum. The alarm is high once the count reaches the holdover limit. It stays high while the block remains in FREEZE or STEER, and clears on entry into CAPTURE or on a new entry into FREEZE.
- R10: Without a strobe, the output word, the state code and the alarm do not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Update strobe; all state advances on it |
| ref_ok_i | input | 1 | Reference valid |
| loop_word_i | input | W | Signed control word from the loop filter |
| steer_delta_i | input | LW | Signed steering correction for holdover |
| cfg_avg_shift_i | input | SHW | Averaging shift |
| cfg_steer_step_i | input | LW | Largest steering step per application |
| cfg_steer_gap_i | input | LW | Strobes skipped between steering applications |
| cfg_elig_len_i | input | LW | Valid strobes needed before capture |
| cfg_hold_max_i | input | LW | Holdover strobes before the alarm |
| cfg_rec_step_i | input | LW | Largest word change per capture strobe |
| cfg_lock_tol_i | input | LW | Difference that ends capture |
| freq_word_o | output | W | Signed control word to the oscillator |
| state_o | output | 3 | State code |
| hold_alarm_o | output | 1 | Holdover time exceeded |

## Verification
The hardest situation to reach is a reference that drops again partway through capture. The output word must then be frozen at a value that is neither the average nor the loop word. The block must also still respect the eligibility count, the steering gap and the holdover alarm on its second trip through holdover.

The bench gets there with a directed run: the loop word is placed far from the held word, so capture needs many bounded steps, and the reference is cut in the middle of that walk. Random episodes of loss, glitchy return and long validity then revisit the same path under varied limits and strobe spacing. A bench model predicts the word, state and alarm on every cycle.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  typedef enum logic [2:0] {
    ST_TRACK   = 3'd0,
    ST_FREEZE  = 3'd1,
    ST_STEER   = 3'd2,
    ST_CAPTURE = 3'd3
  } hfc_state_e;
endpackage

// File: rtl/hfc_clamp.sv
// Symmetric signed limiter: result stays in [-lim, +lim].
module hfc_clamp #(
  parameter int DW = 25,
  parameter int LW = 16
) (
  input  logic signed [DW-1:0] d_i,
  input  logic        [LW-1:0] lim_i,
  output logic signed [DW-1:0] q_o
);
  logic signed [DW-1:0] lim_p;
  logic signed [DW-1:0] lim_n;

  assign lim_p = $signed({{(DW-LW){1'b0}}, lim_i});
  assign lim_n = -lim_p;

  always_comb begin
    if (d_i > lim_p)      q_o = lim_p;
    else if (d_i < lim_n) q_o = lim_n;
    else                  q_o = d_i;
  end
endmodule

// File: rtl/hfc_ema.sv
// Shift-based exponential average of the loop word.
module hfc_ema #(
  parameter int W   = 24,
  parameter int SHW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_i,
  input  logic signed [W-1:0] sample_i,
  input  logic [SHW-1:0]      shift_i,
  output logic signed [W-1:0] avg_o
);
  logic signed [W:0]   diff;
  logic signed [W:0]   inc;
  logic signed [W-1:0] avg_q;
  logic signed [W-1:0] avg_d;

  assign diff  = $signed({sample_i[W-1], sample_i}) - $signed({avg_q[W-1], avg_q});
  assign inc   = diff >>> shift_i;
  assign avg_d = avg_q + inc[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     avg_q <= '0;
    else if (upd_i) avg_q <= avg_d;
  end

  assign avg_o = avg_q;
endmodule

// File: rtl/hfc_guard.sv
// Eligibility window and holdover timer with alarm.
module hfc_guard #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic          in_hold_i,
  input  logic          enter_i,
  input  logic          ref_ok_i,
  input  logic [LW-1:0] elig_len_i,
  input  logic [LW-1:0] hold_max_i,
  output logic          elig_done_o,
  output logic          alarm_o
);
  logic [LW-1:0] elig_q, elig_d;
  logic [LW-1:0] hold_q, hold_d;
  logic          alarm_q, alarm_d;
  logic [LW:0]   elig_inc;
  logic [LW:0]   elig_need;
  logic [LW:0]   hold_inc;
  logic [LW-1:0] hold_sat;
  logic          en;

  assign elig_inc    = {1'b0, elig_q} + 1'b1;
  assign elig_need   = (elig_len_i == '0) ? {{LW{1'b0}}, 1'b1} : {1'b0, elig_len_i};
  assign elig_done_o = stb_i & in_hold_i & ref_ok_i & (elig_inc >= elig_need);
  assign hold_inc    = {1'b0, hold_q} + 1'b1;
  assign hold_sat    = hold_inc[LW] ? hold_q : hold_inc[LW-1:0];
  assign en          = stb_i & (enter_i | in_hold_i);

  always_comb begin
    elig_d  = elig_q;
    hold_d  = hold_q;
    alarm_d = alarm_q;
    if (enter_i || elig_done_o) begin
      elig_d  = '0;
      hold_d  = '0;
      alarm_d = 1'b0;
    end else begin
      elig_d  = ref_ok_i ? elig_inc[LW-1:0] : '0;
      hold_d  = hold_sat;
      alarm_d = (hold_sat >= hold_max_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q  <= '0;
      hold_q  <= '0;
      alarm_q <= 1'b0;
    end else if (en) begin
      elig_q  <= elig_d;
      hold_q  <= hold_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/hfc_holdover_ctrl.sv
module hfc_holdover_ctrl
  import hfc_pkg::*;
#(
  parameter int W   = 24,
  parameter int LW  = 16,
  parameter int SHW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb_i,
  input  logic                 ref_ok_i,
  input  logic signed [W-1:0]  loop_word_i,
  input  logic signed [LW-1:0] steer_delta_i,
  input  logic [SHW-1:0]       cfg_avg_shift_i,
  input  logic [LW-1:0]        cfg_steer_step_i,
  input  logic [LW-1:0]        cfg_steer_gap_i,
  input  logic [LW-1:0]        cfg_elig_len_i,
  input  logic [LW-1:0]        cfg_hold_max_i,
  input  logic [LW-1:0]        cfg_rec_step_i,
  input  logic [LW-1:0]        cfg_lock_tol_i,
  output logic signed [W-1:0]  freq_word_o,
  output logic [2:0]           state_o,
  output logic                 hold_alarm_o
);
  localparam int DW = W + 1;

  hfc_state_e          state_q, state_d;
  logic signed [W-1:0] word_q, word_d;
  logic [LW-1:0]       gap_q, gap_d;

  logic                in_hold;
  logic                is_track, is_capt;
  logic                enter_freeze;
  logic                avg_upd;
  logic                elig_done;
  logic signed [W-1:0] avg;
  logic signed [DW-1:0] steer_ext, steer_lim;
  logic signed [DW-1:0] rec_diff, rec_lim;
  logic signed [DW-1:0] tol_ext;
  logic                within_tol;

  assign is_track     = (state_q == ST_TRACK);
  assign is_capt      = (state_q == ST_CAPTURE);
  assign in_hold      = (state_q == ST_FREEZE) || (state_q == ST_STEER);
  assign enter_freeze = stb_i & ~ref_ok_i & (is_track | is_capt);
  assign avg_upd      = stb_i & ref_ok_i & (is_track | is_capt);

  hfc_ema #(.W(W), .SHW(SHW)) u_ema (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (avg_upd),
    .sample_i (loop_word_i),
    .shift_i  (cfg_avg_shift_i),
    .avg_o    (avg)
  );

  hfc_guard #(.LW(LW)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_i       (stb_i),
    .in_hold_i   (in_hold),
    .enter_i     (enter_freeze),
    .ref_ok_i    (ref_ok_i),
    .elig_len_i  (cfg_elig_len_i),
    .hold_max_i  (cfg_hold_max_i),
    .elig_done_o (elig_done),
    .alarm_o     (hold_alarm_o)
  );

  assign steer_ext = $signed({{(DW-LW){steer_delta_i[LW-1]}}, steer_delta_i});

  hfc_clamp #(.DW(DW), .LW(LW)) u_steer_lim (
    .d_i   (steer_ext),
    .lim_i (cfg_steer_step_i),
    .q_o   (steer_lim)
  );

  assign rec_diff = $signed({loop_word_i[W-1], loop_word_i}) - $signed({word_q[W-1], word_q});

  hfc_clamp #(.DW(DW), .LW(LW)) u_rec_lim (
    .d_i   (rec_diff),
    .lim_i (cfg_rec_step_i),
    .q_o   (rec_lim)
  );

  assign tol_ext    = $signed({{(DW-LW){1'b0}}, cfg_lock_tol_i});
  assign within_tol = (rec_diff <= tol_ext) && (rec_diff >= -tol_ext);

  // Next-state and next-word logic, evaluated for a strobe.
  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_TRACK: begin
        if (ref_ok_i) begin
          word_d = loop_word_i;
        end else begin
          state_d = ST_FREEZE;
          word_d  = avg;
          gap_d   = '0;
        end
      end
      ST_FREEZE: begin
        state_d = elig_done ? ST_CAPTURE : ST_STEER;
      end
      ST_STEER: begin
        if (elig_done) begin
          state_d = ST_CAPTURE;
        end else if (gap_q == '0) begin
          word_d = word_q + steer_lim[W-1:0];
          gap_d  = cfg_steer_gap_i;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      ST_CAPTURE: begin
        if (!ref_ok_i) begin
          state_d = ST_FREEZE;
          gap_d   = '0;
        end else begin
          word_d = word_q + rec_lim[W-1:0];
          if (within_tol) state_d = ST_TRACK;
        end
      end
      default: state_d = ST_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TRACK;
      word_q  <= '0;
      gap_q   <= '0;
    end else if (stb_i) begin
      state_q <= state_d;
      word_q  <= word_d;
      gap_q   <= gap_d;
    end
  end

  assign freq_word_o = word_q;
  assign state_o     = state_q;
endmodule

// File: rtl/hfc_holdover_ctrl_chk.sv
module hfc_holdover_ctrl_chk
  import hfc_pkg::*;
#(
  parameter int W  = 24,
  parameter int LW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stb_i,
  input logic                ref_ok_i,
  input logic [LW-1:0]       cfg_steer_step_i,
  input logic [LW-1:0]       cfg_rec_step_i,
  input logic signed [W-1:0] freq_word_o,
  input logic [2:0]          state_o,
  input logic                hold_alarm_o
);
  logic                prev_stb;
  logic                prev_ok;
  logic [2:0]          prev_state;
  logic signed [W-1:0] prev_word;
  logic [LW-1:0]       prev_step;
  logic [LW-1:0]       prev_rec;
  logic signed [W:0]   dw;
  logic [W:0]          step_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_stb   <= 1'b0;
      prev_ok    <= 1'b0;
      prev_state <= 3'd0;
      prev_word  <= '0;
      prev_step  <= '0;
      prev_rec   <= '0;
    end else begin
      prev_stb   <= stb_i;
      prev_ok    <= ref_ok_i;
      prev_state <= state_o;
      prev_word  <= freq_word_o;
      prev_step  <= cfg_steer_step_i;
      prev_rec   <= cfg_rec_step_i;
    end
  end

  assign dw       = $signed({freq_word_o[W-1], freq_word_o}) - $signed({prev_word[W-1], prev_word});
  assign step_mag = (dw < 0) ? $unsigned(-dw) : $unsigned(dw);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd3);  // R1

  AST_LOSS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_stb && prev_state == ST_TRACK && !prev_ok) |-> state_o == ST_FREEZE);  // R3

  AST_FREEZE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_stb && prev_state == ST_FREEZE) |->
      ((state_o == ST_STEER || state_o == ST_CAPTURE) && freq_word_o == prev_word));  // R4

  AST_STEER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_stb && prev_state == ST_STEER) |-> step_mag <= {{(W+1-LW){1'b0}}, prev_step});  // R5

  AST_REC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_stb && prev_state == ST_CAPTURE) |-> step_mag <= {{(W+1-LW){1'b0}}, prev_rec});  // R7

  AST_REFREEZE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_stb && prev_state == ST_CAPTURE && !prev_ok) |->
      (state_o == ST_FREEZE && freq_word_o == prev_word));  // R8

  AST_ALARM_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_alarm_o |-> (state_o == ST_FREEZE || state_o == ST_STEER));  // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> ($stable(freq_word_o) && $stable(state_o) && $stable(hold_alarm_o)));  // R10
endmodule

bind hfc_holdover_ctrl hfc_holdover_ctrl_chk #(.W(W), .LW(LW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .stb_i            (stb_i),
  .ref_ok_i         (ref_ok_i),
  .cfg_steer_step_i (cfg_steer_step_i),
  .cfg_rec_step_i   (cfg_rec_step_i),
  .freq_word_o      (freq_word_o),
  .state_o          (state_o),
  .hold_alarm_o     (hold_alarm_o)
);

// File: tb/tb_hfc_holdover_ctrl.sv
module tb_hfc_holdover_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 24;
  localparam int LW  = 16;
  localparam int SHW = 5;

  logic                 clk;
  logic                 rst_n;
  logic                 stb;
  logic                 ref_ok;
  logic signed [W-1:0]  loop_w;
  logic signed [LW-1:0] steer;
  logic [SHW-1:0]       c_shift;
  logic [LW-1:0]        c_step, c_gap, c_elig, c_hold, c_rec, c_tol;
  logic signed [W-1:0]  word;
  logic [2:0]           state;
  logic                 alarm;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  int                  m_state;
  logic signed [W-1:0] m_word, m_avg;
  int                  m_gap, m_elig, m_hold;
  bit                  m_alarm;
  string               m_tag;

  hfc_holdover_ctrl #(.W(W), .LW(LW), .SHW(SHW)) dut (
    .clk (clk), .rst_n (rst_n), .stb_i (stb), .ref_ok_i (ref_ok),
    .loop_word_i (loop_w), .steer_delta_i (steer),
    .cfg_avg_shift_i (c_shift), .cfg_steer_step_i (c_step),
    .cfg_steer_gap_i (c_gap), .cfg_elig_len_i (c_elig),
    .cfg_hold_max_i (c_hold), .cfg_rec_step_i (c_rec),
    .cfg_lock_tol_i (c_tol),
    .freq_word_o (word), .state_o (state), .hold_alarm_o (alarm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic signed [W-1:0] ema_f(logic signed [W-1:0] a,
                                                logic signed [W-1:0] s, int sh);
    logic signed [W:0] d;
    d = $signed({s[W-1], s}) - $signed({a[W-1], a});
    d = d >>> sh;
    return a + d[W-1:0];
  endfunction

  function automatic logic signed [W:0] clamp_f(logic signed [W:0] d, logic [LW-1:0] lim);
    logic signed [W:0] lp;
    lp = $signed({9'd0, lim});
    if (d > lp) return lp;
    if (d < -lp) return -lp;
    return d;
  endfunction

  task automatic model_step(bit ok, logic signed [W-1:0] lw, logic signed [LW-1:0] sd);
    int need;
    bit eldone;
    logic signed [W:0] diff, cl;
    int dd;
    need = (c_elig == 0) ? 1 : int'(c_elig);
    case (m_state)
      0: begin
        if (ok) begin
          m_tag = "R2"; m_avg = ema_f(m_avg, lw, int'(c_shift)); m_word = lw;
        end else begin
          m_tag = "R3"; m_state = 1; m_word = m_avg;
          m_gap = 0; m_elig = 0; m_hold = 0; m_alarm = 0;
        end
      end
      1, 2: begin
        eldone = ok && (m_elig + 1 >= need);
        if (eldone) begin
          m_tag = "R6"; m_state = 3; m_elig = 0; m_hold = 0; m_alarm = 0;
        end else begin
          m_tag = (m_state == 1) ? "R4" : "R5";
          m_elig = ok ? m_elig + 1 : 0;
          m_hold = (m_hold == 65535) ? 65535 : m_hold + 1;
          m_alarm = (m_hold >= int'(c_hold));
          if (m_state == 2) begin
            if (m_gap == 0) begin
              cl = clamp_f($signed({{(W+1-LW){sd[LW-1]}}, sd}), c_step);
              m_word = m_word + cl[W-1:0];
              m_gap = int'(c_gap);
            end else m_gap = m_gap - 1;
          end
          m_state = 2;
        end
      end
      default: begin
        if (!ok) begin
          m_tag = "R8"; m_state = 1; m_gap = 0; m_elig = 0; m_hold = 0; m_alarm = 0;
        end else begin
          m_tag = "R7";
          m_avg = ema_f(m_avg, lw, int'(c_shift));
          diff = $signed({lw[W-1], lw}) - $signed({m_word[W-1], m_word});
          dd = int'(diff);
          cl = clamp_f(diff, c_rec);
          m_word = m_word + cl[W-1:0];
          if (dd <= int'(c_tol) && dd >= -int'(c_tol)) m_state = 0;
        end
      end
    endcase
  endtask

  task automatic check(string tag);
    vectors++;
    if (word !== m_word || state !== 3'(m_state)) begin
      fails++;
      $display("FAIL %s: word=%0d state=%0d expected word=%0d state=%0d",
               tag, word, state, m_word, m_state);
    end
    if (alarm !== m_alarm) begin
      fails++;
      $display("FAIL R9: alarm=%0b expected %0b", alarm, m_alarm);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next falling edge.
  task automatic cyc(bit s, bit ok, logic signed [W-1:0] lw, logic signed [LW-1:0] sd);
    stb = s; ref_ok = ok; loop_w = lw; steer = sd;
    if (s) model_step(ok, lw, sd);
    else m_tag = "R10";
    @(posedge clk);
    @(negedge clk);
    check(m_tag);
  endtask

  task automatic set_cfg(int sh, int st, int gp, int el, int ho, int rc, int tl);
    c_shift = SHW'(sh); c_step = LW'(st); c_gap = LW'(gp); c_elig = LW'(el);
    c_hold = LW'(ho); c_rec = LW'(rc); c_tol = LW'(tl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic signed [W-1:0] lw;
    int ok_left, bad_left;
    bit ok;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; stb = 0; ref_ok = 0; loop_w = '0; steer = '0;
    set_cfg(3, 50, 2, 3, 6, 100, 40);
    m_state = 0; m_word = '0; m_avg = '0; m_gap = 0; m_elig = 0; m_hold = 0; m_alarm = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2: tracking ramp builds the average
    for (int i = 0; i < 40; i++) cyc(1, 1, W'(1000 + 37 * i), '0);
    // R10: idle cycles with wild inputs
    for (int i = 0; i < 4; i++) cyc(0, i[0], W'(-90000), 16'sd3000);
    // R3: loss freezes at the average, R4 freeze, R5 clipped and spaced steering
    cyc(1, 0, W'(77777), '0);
    for (int i = 0; i < 9; i++) cyc(1, 0, W'(-5), 16'sd900);
    // R9: alarm stays while holding; R6 glitchy return
    cyc(1, 1, W'(9000), -16'sd20);
    cyc(1, 1, W'(9000), -16'sd20);
    cyc(1, 0, W'(9000), -16'sd20);
    cyc(1, 1, W'(9000), -16'sd20);
    cyc(1, 1, W'(9000), -16'sd20);
    cyc(1, 1, W'(9000), -16'sd20);
    // R7 bounded walk, then R8 drop mid-capture
    for (int i = 0; i < 5; i++) cyc(1, 1, W'(9000), '0);
    cyc(1, 0, W'(9000), '0);
    set_cfg(2, 10, 0, 1, 3, 100, 40);
    for (int i = 0; i < 4; i++) cyc(1, 0, W'(9000), -16'sd500);
    for (int i = 0; i < 80; i++) cyc(1, 1, W'(9000), '0);

    // Random episodes under varied limits
    lw = W'(9000); ok = 1; ok_left = 20; bad_left = 0;
    for (int ph = 0; ph < 8; ph++) begin
      set_cfg($urandom % 8, 1 + $urandom % 300, $urandom % 4, $urandom % 7,
              1 + $urandom % 30, 1 + $urandom % 400, $urandom % 200);
      for (int i = 0; i < 2500; i++) begin
        if (ok && ok_left == 0) begin ok = 0; bad_left = 1 + $urandom % 40; end
        else if (!ok && bad_left == 0) begin ok = 1; ok_left = 1 + $urandom % 120; end
        if (ok) ok_left--; else bad_left--;
        lw = lw + W'(int'($urandom % 128) - 64);
        cyc(($urandom % 3) == 0, (ok && ($urandom % 16 != 0)) || (!ok && ($urandom % 10 == 0)),
            lw, LW'(int'($urandom % 4001) - 2000));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule